// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block searches for the three divider settings of a frequency synthesizer: an input divider M, a feedback multiplier N and a post divider PL. It takes a reference frequency and a target output frequency, both in kHz. The output it aims for is ref·N/(M·PL). The comparison frequency ref/M, the oscillator frequency ref·N/M and every divider setting must stay inside fixed limits. These limits are parameters.

A single request starts on a one-cycle `start` pulse. The engine first works out the range of post-divider values worth trying. It then walks PL upward, M upward inside each PL, and the one or two N values that bracket the oscillator target. Every division goes through one shared, multi-cycle restoring divider. The engine keeps the candidate with the smallest error. It can stop early on an exact hit. When best-fit mode is off, it can also stop early on a candidate that is close enough. When the search ends, it raises `done` for one cycle and shows the chosen M, N, PL and the resulting frequency.

Top module: `pll_coef_search`

## Requirements
- R1: The padded oscillator target is target + target/50. The oscillator ceiling is the larger of its limit (2600000) and the padded target. Only PL values from floor(1300000/padded) to ceil(ceiling/padded) are tried, each bound first clamped into 1..31, in ascending order.
- R2: For each PL, M runs upward from 1 to 255. When ref/M falls below 12000, no larger M is tried for that PL. When ref/M is above 38400, that M is skipped.
- R3: For each M, N runs from floor(target·PL·M/ref) up to the ceiling of the same quotient. If that floor is above 255, no larger M is tried for that PL. Values of N below 8 are skipped.
- R4: A candidate is considered only when its oscillator frequency ref·N/M (truncated) lies within 1300000 and the ceiling of R1, both included. Its error is the absolute difference between round-to-nearest (vco + PL/2)/PL and the target.
- R5: The kept candidate is replaced only by one whose error is strictly smaller. On equal error the earlier one in scan order wins.
- R6: A candidate with zero error ends the search at once.
- R7: With `bestFit` low, a new best candidate whose floor(vco/error) is above 218 ends the search at once. With `bestFit` high only R6 ends it early.
- R8: `freqKhz` is ref·N/(M·PL) for the reported settings, computed with truncating division.
- R9: If no candidate qualifies, `noMatch` is 1 and the outputs are M=255, N=8, PL=1, with `freqKhz` computed as in R8. Otherwise `noMatch` is 0.
- R10: After reset `busy`, `done` and `noMatch` are 0 and the setting outputs are 0. `busy` rises the cycle after an accepted `start` and falls in the cycle `done` pulses. `done` lasts one cycle. The result outputs change only at that pulse.
- R11: A `start` pulse while `busy` is high is ignored. The running search finishes with the inputs sampled when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; samples refKhz, targetKhz, bestFit |
| bestFit | input | 1 | 1 = search for the smallest error, 0 = accept a close-enough result |
| refKhz | input | FREQ_W (32) | Reference frequency in kHz |
| targetKhz | input | FREQ_W (32) | Wanted output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| noMatch | output | 1 | No candidate satisfied the limits |
| mSel | output | M_W (8) | Chosen input divider |
| nSel | output | N_W (8) | Chosen feedback multiplier |
| plSel | output | PL_W (5) | Chosen post divider |
| freqKhz | output | FREQ_W (32) | Resulting output frequency in kHz |

## Verification
The bench builds the engine with its default parameters: 32-bit frequencies, 8-bit M and N, a 5-bit PL and the default limits. Each division therefore takes a 45-bit pass through the serial divider.
With these limits, a reference below 12000 kHz leaves the search empty. A reference near 100000 kHz makes the low M values exceed the comparison ceiling. A target above 2549 MHz raises the oscillator ceiling. A target near 128 MHz opens a post-divider window of about a dozen values.
Random references between 12000 and 38400 kHz and random targets, with both settings of the best-fit mode, are compared with a behavioural search model. A second start pulse in the middle of a search tests that busy requests are ignored.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_PAD, OP_HI, OP_LO, OP_CMP, OP_NLO, OP_VCO, OP_OUT, OP_FRQ
  } div_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PAD, S_HI, S_LO, S_PLINIT, S_PLCHK, S_MCHK, S_UCHK,
    S_NCHK, S_NLOOP, S_VCHK, S_ECHK, S_FIN, S_DONE, S_WAIT
  } pcs_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    divGo;
    div_op_e divOp;
    logic    plInit;
    logic    plInc;
    logic    mInit;
    logic    mInc;
    logic    nInc;
    logic    bestUpd;
    logic    finish;
  } pcs_ctrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic divDone;
    logic plOver;
    logic mOver;
    logic cmpLow;
    logic cmpHigh;
    logic nOverMax;
    logic nPastHi;
    logic nLow;
    logic vcoOk;
    logic better;
    logic accept;
  } pcs_stat_t;

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int DW = 45
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dReg;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   shifted;
  logic [DW+1:0] trial;

  assign shifted = {rem, quot[DW-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dReg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dReg <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
      quot <= '0; rem <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem  <= '0;
        quot <= dividend;
        dReg <= divisor;
        cnt  <= CW'(DW);
        run  <= 1'b1;
      end else if (run) begin
        if (!trial[DW+1]) begin
          rem  <= trial[DW-1:0];
          quot <= {quot[DW-2:0], 1'b1};
        end else begin
          rem  <= shifted[DW-1:0];
          quot <= {quot[DW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // truncating quotient: remainder below divisor when result is presented
  assert_div_rem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dReg == '0 || rem < dReg));

endmodule

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  pcs_stat_t stat,
  output pcs_ctrl_t ctrl,
  output logic      busy
);
  pcs_state_e state, nxt, retState, nxtRet;

  assign busy = (state != S_IDLE);

  always_comb begin
    ctrl   = '0;
    nxt    = state;
    nxtRet = retState;
    case (state)
      S_IDLE:   if (start) begin ctrl.load = 1'b1; nxt = S_PAD; end
      S_PAD:    begin ctrl.divGo = 1'b1; ctrl.divOp = OP_PAD; nxtRet = S_HI;     nxt = S_WAIT; end
      S_HI:     begin ctrl.divGo = 1'b1; ctrl.divOp = OP_HI;  nxtRet = S_LO;     nxt = S_WAIT; end
      S_LO:     begin ctrl.divGo = 1'b1; ctrl.divOp = OP_LO;  nxtRet = S_PLINIT; nxt = S_WAIT; end
      S_PLINIT: begin ctrl.plInit = 1'b1; nxt = S_PLCHK; end
      S_PLCHK:
        if (stat.plOver) nxt = S_FIN;
        else begin ctrl.mInit = 1'b1; nxt = S_MCHK; end
      S_MCHK:
        if (stat.mOver) begin ctrl.plInc = 1'b1; nxt = S_PLCHK; end
        else begin ctrl.divGo = 1'b1; ctrl.divOp = OP_CMP; nxtRet = S_UCHK; nxt = S_WAIT; end
      S_UCHK:
        if (stat.cmpLow)       begin ctrl.plInc = 1'b1; nxt = S_PLCHK; end
        else if (stat.cmpHigh) begin ctrl.mInc  = 1'b1; nxt = S_MCHK;  end
        else begin ctrl.divGo = 1'b1; ctrl.divOp = OP_NLO; nxtRet = S_NCHK; nxt = S_WAIT; end
      S_NCHK:
        if (stat.nOverMax) begin ctrl.plInc = 1'b1; nxt = S_PLCHK; end
        else nxt = S_NLOOP;
      S_NLOOP:
        if (stat.nPastHi || stat.nOverMax) begin ctrl.mInc = 1'b1; nxt = S_MCHK; end
        else if (stat.nLow) ctrl.nInc = 1'b1;
        else begin ctrl.divGo = 1'b1; ctrl.divOp = OP_VCO; nxtRet = S_VCHK; nxt = S_WAIT; end
      S_VCHK:
        if (stat.vcoOk) begin ctrl.divGo = 1'b1; ctrl.divOp = OP_OUT; nxtRet = S_ECHK; nxt = S_WAIT; end
        else begin ctrl.nInc = 1'b1; nxt = S_NLOOP; end
      S_ECHK: begin
        ctrl.bestUpd = stat.better;
        if (stat.accept) nxt = S_FIN;
        else begin ctrl.nInc = 1'b1; nxt = S_NLOOP; end
      end
      S_FIN:    begin ctrl.divGo = 1'b1; ctrl.divOp = OP_FRQ; nxtRet = S_DONE; nxt = S_WAIT; end
      S_DONE:   begin ctrl.finish = 1'b1; nxt = S_IDLE; end
      S_WAIT:   if (stat.divDone) nxt = retState;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
    end else begin
      state    <= nxt;
      retState <= nxtRet;
    end
  end

  // a request is only taken when idle
  assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load |-> !busy);

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int M_W     = 8,
  parameter int N_W     = 8,
  parameter int PL_W    = 5,
  parameter int MIN_VCO = 1300000,
  parameter int MAX_VCO = 2600000,
  parameter int MIN_CMP = 12000,
  parameter int MAX_CMP = 38400,
  parameter int MIN_M   = 1,
  parameter int MAX_M   = 255,
  parameter int MIN_N   = 8,
  parameter int MAX_N   = 255,
  parameter int MIN_PL  = 1,
  parameter int MAX_PL  = 31,
  parameter int PAD_DIV = 50,
  parameter int ACC_RATIO = 218
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcs_ctrl_t         ctrl,
  input  logic              bestFitIn,
  input  logic [FREQ_W-1:0] refIn,
  input  logic [FREQ_W-1:0] tgtIn,
  output pcs_stat_t         stat,
  output logic              done,
  output logic              noMatch,
  output logic [M_W-1:0]    mSel,
  output logic [N_W-1:0]    nSel,
  output logic [PL_W-1:0]   plSel,
  output logic [FREQ_W-1:0] freqKhz
);
  localparam int DW  = FREQ_W + PL_W + M_W;
  localparam int PLR = PL_W + 1;
  localparam int MR  = M_W + 1;
  localparam int XW  = DW + 9;
  localparam logic [DW-1:0] MIN_VCO_W = DW'(MIN_VCO);
  localparam logic [DW-1:0] MAX_VCO_W = DW'(MAX_VCO);
  localparam logic [DW-1:0] MIN_CMP_W = DW'(MIN_CMP);
  localparam logic [DW-1:0] MAX_CMP_W = DW'(MAX_CMP);
  localparam logic [DW-1:0] MIN_N_W   = DW'(MIN_N);
  localparam logic [DW-1:0] MAX_N_W   = DW'(MAX_N);
  localparam logic [DW-1:0] MIN_PL_W  = DW'(MIN_PL);
  localparam logic [DW-1:0] MAX_PL_W  = DW'(MAX_PL);

  logic [FREQ_W-1:0] refR, tgtR;
  logic              bfR, found;
  logic [DW-1:0]     padded, maxV, cmpVal, nCur, nHi, vco, outVal, freqRes, bestDelta;
  logic [PLR-1:0]    pl, plLo, plHi;
  logic [MR-1:0]     m;
  logic [M_W-1:0]    bestM;
  logic [N_W-1:0]    bestN;
  logic [PL_W-1:0]   bestPL;
  div_op_e           opR;

  logic [DW-1:0] refW, tgtW, plW, mW, vt, dividend, divisor, quot, rem, delta, padSum;
  logic [XW-1:0] vcoX, errX;
  logic          divDone;

  assign refW = DW'(refR);
  assign tgtW = DW'(tgtR);
  assign plW  = DW'(pl);
  assign mW   = DW'(m);
  assign vt   = tgtW * plW;
  assign padSum = tgtW + quot;

  always_comb begin
    dividend = '0;
    divisor  = '1;
    case (ctrl.divOp)
      OP_PAD: begin dividend = tgtW;                      divisor = DW'(PAD_DIV); end
      OP_HI:  begin dividend = maxV + padded - 1'b1;      divisor = padded; end
      OP_LO:  begin dividend = MIN_VCO_W;                 divisor = padded; end
      OP_CMP: begin dividend = refW;                      divisor = mW; end
      OP_NLO: begin dividend = vt * mW;                   divisor = refW; end
      OP_VCO: begin dividend = refW * nCur;               divisor = mW; end
      OP_OUT: begin dividend = vco + (plW >> 1);          divisor = plW; end
      OP_FRQ: begin dividend = refW * DW'(bestN);         divisor = DW'(bestM) * DW'(bestPL); end
      default: ;
    endcase
  end

  pcs_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(ctrl.divGo),
    .dividend(dividend), .divisor(divisor),
    .done(divDone), .quot(quot), .rem(rem)
  );

  function automatic logic [PLR-1:0] clampPl(input logic [DW-1:0] q);
    if (q < MIN_PL_W)      return PLR'(MIN_PL);
    else if (q > MAX_PL_W) return PLR'(MAX_PL);
    else                   return q[PLR-1:0];
  endfunction

  assign delta = (outVal > tgtW) ? outVal - tgtW : tgtW - outVal;
  assign vcoX  = XW'(vco);
  assign errX  = XW'(ACC_RATIO + 1) * XW'(delta);

  assign stat.divDone  = divDone;
  assign stat.plOver   = pl > plHi;
  assign stat.mOver    = m > MR'(MAX_M);
  assign stat.cmpLow   = cmpVal < MIN_CMP_W;
  assign stat.cmpHigh  = cmpVal > MAX_CMP_W;
  assign stat.nOverMax = nCur > MAX_N_W;
  assign stat.nPastHi  = nCur > nHi;
  assign stat.nLow     = nCur < MIN_N_W;
  assign stat.vcoOk    = (vco >= MIN_VCO_W) && (vco <= maxV);
  assign stat.better   = delta < bestDelta;
  assign stat.accept   = stat.better && ((delta == '0) || (!bfR && vcoX >= errX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refR <= '0; tgtR <= '0; bfR <= 1'b0; found <= 1'b0;
      padded <= '0; maxV <= '0; cmpVal <= '0; nCur <= '0; nHi <= '0;
      vco <= '0; outVal <= '0; freqRes <= '0; bestDelta <= '1;
      pl <= '0; plLo <= '0; plHi <= '0; m <= '0;
      bestM <= '0; bestN <= '0; bestPL <= '0; opR <= OP_PAD;
      done <= 1'b0; noMatch <= 1'b0; mSel <= '0; nSel <= '0; plSel <= '0; freqKhz <= '0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        refR <= refIn; tgtR <= tgtIn; bfR <= bestFitIn;
        bestDelta <= '1; found <= 1'b0;
        bestM <= M_W'(MAX_M); bestN <= N_W'(MIN_N); bestPL <= PL_W'(MIN_PL);
      end
      if (ctrl.divGo) opR <= ctrl.divOp;
      if (divDone) begin
        case (opR)
          OP_PAD: begin padded <= padSum; maxV <= (padSum > MAX_VCO_W) ? padSum : MAX_VCO_W; end
          OP_HI:  plHi <= clampPl(quot);
          OP_LO:  plLo <= clampPl(quot);
          OP_CMP: cmpVal <= quot;
          OP_NLO: begin nCur <= quot; nHi <= quot + DW'(rem != '0); end
          OP_VCO: vco <= quot;
          OP_OUT: outVal <= quot;
          OP_FRQ: freqRes <= quot;
          default: ;
        endcase
      end
      if (ctrl.plInit) pl <= plLo;
      if (ctrl.plInc)  pl <= pl + 1'b1;
      if (ctrl.mInit)  m <= MR'(MIN_M);
      if (ctrl.mInc)   m <= m + 1'b1;
      if (ctrl.nInc)   nCur <= nCur + 1'b1;
      if (ctrl.bestUpd) begin
        bestM <= m[M_W-1:0]; bestN <= nCur[N_W-1:0]; bestPL <= pl[PL_W-1:0];
        bestDelta <= delta; found <= 1'b1;
      end
      if (ctrl.finish) begin
        done <= 1'b1; noMatch <= !found;
        mSel <= bestM; nSel <= bestN; plSel <= bestPL;
        freqKhz <= freqRes[FREQ_W-1:0];
      end
    end
  end

  assert_pl_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bestUpd |-> (pl >= plLo && pl <= plHi));
  assert_cmp_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bestUpd |-> (cmpVal >= MIN_CMP_W && cmpVal <= MAX_CMP_W && m <= MR'(MAX_M)));
  assert_n_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bestUpd |-> (nCur >= MIN_N_W && nCur <= MAX_N_W && nCur <= nHi));
  assert_vco_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bestUpd |-> (vco >= MIN_VCO_W && vco <= maxV));
  assert_err_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.load |=> bestDelta <= $past(bestDelta));

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pcs_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int M_W     = 8,
  parameter int N_W     = 8,
  parameter int PL_W    = 5,
  parameter int MIN_VCO = 1300000,
  parameter int MAX_VCO = 2600000,
  parameter int MIN_CMP = 12000,
  parameter int MAX_CMP = 38400,
  parameter int MIN_M   = 1,
  parameter int MAX_M   = 255,
  parameter int MIN_N   = 8,
  parameter int MAX_N   = 255,
  parameter int MIN_PL  = 1,
  parameter int MAX_PL  = 31,
  parameter int PAD_DIV = 50,
  parameter int ACC_RATIO = 218
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bestFit,
  input  logic [FREQ_W-1:0] refKhz,
  input  logic [FREQ_W-1:0] targetKhz,
  output logic              busy,
  output logic              done,
  output logic              noMatch,
  output logic [M_W-1:0]    mSel,
  output logic [N_W-1:0]    nSel,
  output logic [PL_W-1:0]   plSel,
  output logic [FREQ_W-1:0] freqKhz
);
  pcs_ctrl_t ctrl;
  pcs_stat_t stat;

  pcs_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stat(stat), .ctrl(ctrl), .busy(busy)
  );

  pcs_datapath #(
    .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .PL_W(PL_W),
    .MIN_VCO(MIN_VCO), .MAX_VCO(MAX_VCO), .MIN_CMP(MIN_CMP), .MAX_CMP(MAX_CMP),
    .MIN_M(MIN_M), .MAX_M(MAX_M), .MIN_N(MIN_N), .MAX_N(MAX_N),
    .MIN_PL(MIN_PL), .MAX_PL(MAX_PL), .PAD_DIV(PAD_DIV), .ACC_RATIO(ACC_RATIO)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bestFitIn(bestFit),
    .refIn(refKhz), .tgtIn(targetKhz), .stat(stat),
    .done(done), .noMatch(noMatch), .mSel(mSel), .nSel(nSel),
    .plSel(plSel), .freqKhz(freqKhz)
  );

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({noMatch, mSel, nSel, plSel, freqKhz}));

endmodule

// File: tb/pll_coef_search_tb.sv
`timescale 1ns/1ps
module pll_coef_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bestFit = 1'b0;
  logic [31:0] refKhz = '0, targetKhz = '0;
  logic        busy, done, noMatch;
  logic [7:0]  mSel, nSel;
  logic [4:0]  plSel;
  logic [31:0] freqKhz;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  pll_coef_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bestFit(bestFit),
    .refKhz(refKhz), .targetKhz(targetKhz), .busy(busy), .done(done),
    .noMatch(noMatch), .mSel(mSel), .nSel(nSel), .plSel(plSel), .freqKhz(freqKhz)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural search from the requirements
  task automatic model(input longint r, input longint t, input bit bf,
                       output longint mO, output longint nO, output longint pO,
                       output longint fO, output bit nm);
    longint maxv, pad, hi, lo, bd, vt, u, n, n2, v, lw, d;
    bit stop;
    maxv = 2600000; pad = t + t / 50;
    if (maxv < pad) maxv = pad;
    hi = (maxv + pad - 1) / pad; if (hi > 31) hi = 31; if (hi < 1) hi = 1;
    lo = 1300000 / pad;          if (lo > 31) lo = 31; if (lo < 1) lo = 1;
    bd = 64'h7fffffffffffffff; mO = 255; nO = 8; pO = 1; stop = 0;
    for (longint p = lo; p <= hi && !stop; p++) begin
      vt = t * p;
      for (longint mm = 1; mm <= 255 && !stop; mm++) begin
        u = r / mm;
        if (u < 12000) break;
        if (u > 38400) continue;
        n  = vt * mm / r;
        n2 = (vt * mm + r - 1) / r;
        if (n > 255) break;
        for (; n <= n2 && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          v = r * n / mm;
          if (v >= 1300000 && v <= maxv) begin
            lw = (v + p / 2) / p;
            d  = (lw > t) ? lw - t : t - lw;
            if (d < bd) begin
              bd = d; mO = mm; nO = n; pO = p;
              if (d == 0 || (!bf && v / d > 218)) stop = 1;
            end
          end
        end
      end
    end
    nm = (bd == 64'h7fffffffffffffff);
    fO = r * nO / (mO * pO);
  endtask

  task automatic runSearch(input longint r, input longint t, input bit bf,
                           input string tag, input bit poke);
    longint em, en, ep, ef;
    bit enm;
    int cyc;
    model(r, t, bf, em, en, ep, ef, enm);
    @(negedge clk);
    refKhz = r[31:0]; targetKhz = t[31:0]; bestFit = bf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      // R11: a second request while busy must not disturb the search
      repeat (20) @(negedge clk);
      refKhz = 32'd11000; targetKhz = 32'd2000000; bestFit = ~bf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    if (done !== 1'b1) begin
      check(1'b0, tag, "watchdog", cyc, 60000);
      return;
    end
    check(mSel == em[7:0] && nSel == en[7:0] && plSel == ep[4:0], tag, "M", mSel, em);
    if (!(nSel == en[7:0])) check(1'b0, tag, "N", nSel, en);
    if (!(plSel == ep[4:0])) check(1'b0, tag, "PL", plSel, ep);
    check(freqKhz == ef[31:0], {tag, " R8"}, "freq", freqKhz, ef);
    check(noMatch == enm, {tag, " R9"}, "noMatch", noMatch, enm);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R10", "done width", done, 0);
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && noMatch === 1'b0, "R10", "reset flags", {busy, done, noMatch}, 0);
    check(mSel == 8'd0 && nSel == 8'd0 && plSel == 5'd0 && freqKhz == 32'd0, "R10", "reset outputs", mSel, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 exact: 38400*34 = 1305600, PL=1 -> M=1 N=34 PL=1
    runSearch(38400, 1305600, 1'b1, "R6", 1'b0);
    check(mSel == 8'd1 && nSel == 8'd34 && plSel == 5'd1 && freqKhz == 32'd1305600,
          "R6", "exact settings", {mSel, nSel, plSel}, {8'd1, 8'd34, 5'd1});
    // R9: reference below comparison floor -> no candidate, 11000*8/255 = 345
    runSearch(11000, 1000000, 1'b1, "R9", 1'b0);
    check(noMatch == 1'b1 && mSel == 8'd255 && nSel == 8'd8 && plSel == 5'd1 && freqKhz == 32'd345,
          "R9", "fallback", freqKhz, 345);
    // R2: low M values exceed comparison ceiling
    runSearch(100000, 1000000, 1'b1, "R2", 1'b0);
    // R4: target above padded ceiling raises the oscillator limit
    runSearch(27000, 2600000, 1'b1, "R4", 1'b0);
    // R1: low target opens a wide post-divider window
    runSearch(12000, 128000, 1'b1, "R1", 1'b0);
    // R7: same request with and without best-fit
    runSearch(19200, 999999, 1'b0, "R7", 1'b0);
    runSearch(19200, 999999, 1'b1, "R7", 1'b0);
    // R3: N bracket around a non-integer quotient
    runSearch(26000, 1777777, 1'b1, "R3", 1'b0);
    // R11: start pulse while busy
    runSearch(38400, 700001, 1'b1, "R11", 1'b1);
    // random mix, R5 ties covered by the model's strict comparison
    for (int i = 0; i < 12; i++) begin
      runSearch($urandom_range(38400, 12000), $urandom_range(2600000, 400000),
                1'($urandom_range(1, 0)), "R5", 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule